// File: doc/BRIEF.md
# Edge-Capture Interrupt Controller with Overrun Detect

This block is the local interrupt controller of one core. It watches a set of synchronous interrupt lines and turns them into per-line interrupt requests. The lines form two groups. The global group is wired in parallel to the controller of every core, and each core enables those lines on its own. The private group belongs to this core alone. Each line works in one of two modes. In level mode its status bit tracks the line. In edge mode its status bit latches the line's active edge and holds it until software clears it.

In edge mode an edge can arrive while the line's status bit is still pending. That second edge would be lost, so the block records it in a sticky error bit for that line. The error bits of all lines are ORed into one dedicated error interrupt. Software uses the register port to read status and errors, to clear them with write-one-to-clear, and to program the enables, the polarity and the mode.

Top module: `edge_irq_ctrl`

## Requirements
- R1: In edge mode (bit i of register 4 = 1), an active edge on line i sets status bit i (register 0, bit i). The status bit is readable one cycle after the edge is sampled.
- R2: An edge-mode status bit stays set until a 1 is written to bit i of register 0. When that clear and a new active edge fall in the same cycle, the bit stays set.
- R3: An active edge on an edge-mode line whose status bit is already set sets error bit i (register 1, bit i). A write of 1 to register 1 bit i clears that error bit.
- R4: err_irq_o is high exactly when at least one error bit is set and error-enable (register 5, bit 0) is 1.
- R5: Polarity bit i (register 3) selects the active edge and level of line i: 0 means rising edge and high level, 1 means falling edge and low level.
- R6: irq_o[i] equals status bit i AND enable bit i (register 2, bit i). Registers 2 to 5 read back the value last written to them.
- R7: In level mode (register 4 bit i = 0), status bit i equals line i XOR polarity i, one cycle late. No error bit is set in this mode, and a clear write to register 0 has no effect.
- R8: A line held at its active level produces a single edge event only, so holding it never sets the error bit.
- R9: After reset, every status, error, enable, polarity, mode and error-enable bit is 0. With the lines low, no edge is captured after reset.
- R10: Global lines occupy bits 0 to NUM_GLB-1 of every vector. Private lines occupy bits NUM_GLB to NUM_GLB+NUM_PRV-1. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_line_i | input | NUM_GLB | Global-group interrupt lines (synchronous) |
| prv_line_i | input | NUM_PRV | Private-group interrupt lines (synchronous) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (0 status, 1 error, 2 enable, 3 polarity, 4 mode, 5 error-enable) |
| wdata_i | input | NUM_GLB+NUM_PRV | Register write data |
| rdata_o | output | NUM_GLB+NUM_PRV | Register read data for addr_i (combinational) |
| irq_o | output | NUM_GLB+NUM_PRV | Per-line interrupt requests |
| err_irq_o | output | 1 | Global second-edge error interrupt |

## Verification
The bench drives a clear write in the same cycle as a fresh edge. A design in which the clear wins would lose that event and show status 0. It holds a line at its active level for several cycles. A detector that looks at level instead of transitions would flag a false overrun. It also arms falling polarity on a line that is resting low, where an edge detector with the wrong sense would capture a phantom edge. Last, it runs long random line and clear traffic against a reference model that is checked every cycle, so that errors in level-mode tracking, the error-enable gate and the group bit placement show up.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_ERROR  = 3'd1,
    REG_ENABLE = 3'd2,
    REG_POLAR  = 3'd3,
    REG_MODE   = 3'd4,
    REG_ERREN  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/edge_irq_lane.sv
module edge_irq_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic clr_prim_i,
  input  logic clr_err_i,
  output logic prim_o,
  output logic err_o
);
  logic prev_q, prim_q, err_q;
  logic act_lvl, act_edge;

  assign act_lvl  = line_i ^ pol_i;
  assign act_edge = act_lvl & ~(prev_q ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      prim_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= line_i;
      if (edge_mode_i) begin
        // a new edge beats a same-cycle clear
        prim_q <= act_edge | (prim_q & ~clr_prim_i);
        err_q  <= (act_edge & prim_q) | (err_q & ~clr_err_i);
      end else begin
        prim_q <= act_lvl;
        err_q  <= err_q & ~clr_err_i;
      end
    end
  end

  assign prim_o = prim_q;
  assign err_o  = err_q;

  assert_edge_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && act_edge) |=> prim_q);
  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && prim_q && !clr_prim_i) |=> prim_q);
  assert_second_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && prim_q && act_edge) |=> err_q);
  assert_level_no_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode_i |=> !$rose(err_q));
  assert_level_track_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode_i |=> (prim_q == $past(act_lvl)));
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned AW        = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] prim_i,
  input  logic [NUM_LINES-1:0] err_i,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic                 erren_o,
  output logic [NUM_LINES-1:0] clr_prim_o,
  output logic [NUM_LINES-1:0] clr_err_o,
  output logic [NUM_LINES-1:0] rdata_o
);
  logic [NUM_LINES-1:0] en_q, pol_q, mode_q;
  logic                 erren_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pol_q   <= '0;
      mode_q  <= '0;
      erren_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_ENABLE: en_q    <= wdata_i;
        REG_POLAR:  pol_q   <= wdata_i;
        REG_MODE:   mode_q  <= wdata_i;
        REG_ERREN:  erren_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign clr_prim_o = (wr_en_i && addr_i == REG_STATUS) ? wdata_i : '0;
  assign clr_err_o  = (wr_en_i && addr_i == REG_ERROR)  ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_STATUS: rdata_o = prim_i;
      REG_ERROR:  rdata_o = err_i;
      REG_ENABLE: rdata_o = en_q;
      REG_POLAR:  rdata_o = pol_q;
      REG_MODE:   rdata_o = mode_q;
      REG_ERREN:  rdata_o = {{(NUM_LINES-1){1'b0}}, erren_q};
      default:    rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign mode_o  = mode_q;
  assign erren_o = erren_q;

  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q) && $stable(pol_q) && $stable(mode_q));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_GLB = 4,
  parameter int unsigned NUM_PRV = 4,
  localparam int unsigned NUM_LINES = NUM_GLB + NUM_PRV,
  localparam int unsigned AW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_GLB-1:0]   glb_line_i,
  input  logic [NUM_PRV-1:0]   prv_line_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic                 err_irq_o
);
  logic [NUM_LINES-1:0] lines, prim, err, en, pol, mode, clr_prim, clr_err;
  logic                 erren;

  assign lines = {prv_line_i, glb_line_i};

  edge_irq_regs #(.NUM_LINES(NUM_LINES), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .prim_i(prim), .err_i(err),
    .en_o(en), .pol_o(pol), .mode_o(mode), .erren_o(erren),
    .clr_prim_o(clr_prim), .clr_err_o(clr_err), .rdata_o
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    edge_irq_lane u_lane (
      .clk_i, .rst_ni,
      .line_i(lines[i]), .edge_mode_i(mode[i]), .pol_i(pol[i]),
      .clr_prim_i(clr_prim[i]), .clr_err_i(clr_err[i]),
      .prim_o(prim[i]), .err_o(err[i])
    );
  end

  assign irq_o     = prim & en;
  assign err_irq_o = erren & (|err);

  assert_err_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_irq_o) |-> erren);
  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~en) == '0);
  assert_err_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (err != '0));
endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;
  localparam int NP = 4;
  localparam int N  = NG + NP;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] line = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, irq;
  logic         err_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl #(.NUM_GLB(NG), .NUM_PRV(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .glb_line_i(line[NG-1:0]), .prv_line_i(line[N-1:NG]),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .err_irq_o(err_irq)
  );

  // behavioural reference
  bit m_prev[N], m_st[N], m_err[N], m_en[N], m_pol[N], m_mode[N];
  bit m_een;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_st[i]) begin
        m_prev[i] = 0; m_st[i] = 0; m_err[i] = 0;
        m_en[i] = 0; m_pol[i] = 0; m_mode[i] = 0;
      end
      m_een = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit cur_act, prev_act, edge_seen, clr_s, clr_e;
        cur_act   = line[i] != m_pol[i];
        prev_act  = m_prev[i] != m_pol[i];
        edge_seen = cur_act && !prev_act;
        clr_s = wr_en && addr == 3'd0 && wdata[i];
        clr_e = wr_en && addr == 3'd1 && wdata[i];
        if (clr_e) m_err[i] = 0;
        if (m_mode[i]) begin
          if (edge_seen && m_st[i]) m_err[i] = 1;
          if (clr_s) m_st[i] = 0;
          if (edge_seen) m_st[i] = 1;
        end else begin
          m_st[i] = cur_act;
        end
        m_prev[i] = line[i];
      end
      if (wr_en) begin
        for (int i = 0; i < N; i++) begin
          if (addr == 3'd2) m_en[i] = wdata[i];
          if (addr == 3'd3) m_pol[i] = wdata[i];
          if (addr == 3'd4) m_mode[i] = wdata[i];
        end
        if (addr == 3'd5) m_een = wdata[0];
      end
    end
  end

  function automatic logic [N-1:0] m_read(input logic [2:0] a);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      case (a)
        3'd0: v[i] = m_st[i];
        3'd1: v[i] = m_err[i];
        3'd2: v[i] = m_en[i];
        3'd3: v[i] = m_pol[i];
        3'd4: v[i] = m_mode[i];
        default: v[i] = 1'b0;
      endcase
    end
    if (a == 3'd5) v[0] = m_een;
    return v;
  endfunction

  function automatic logic [N-1:0] m_irq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_st[i] & m_en[i];
    return v;
  endfunction

  function automatic logic m_errirq();
    logic any = 0;
    for (int i = 0; i < N; i++) any |= m_err[i];
    return any & m_een;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 irq_o", irq, m_irq());
      check("R4 err_irq_o", {{(N-1){1'b0}}, err_irq}, {{(N-1){1'b0}}, m_errirq()});
      case (addr)
        3'd0: check("R1 status read", rdata, m_read(addr));
        3'd1: check("R3 error read", rdata, m_read(addr));
        3'd6, 3'd7: check("R10 unused read", rdata, m_read(addr));
        default: check("R6 config read", rdata, m_read(addr));
      endcase
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a);
    addr = a;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(3'd0); check("R9 status after reset", rdata, '0);
    rd(3'd4); check("R9 mode after reset", rdata, '0);
    check("R9 irq after reset", irq, '0);

    tick();
    wr(3'd4, '1);
    wr(3'd2, '1);
    wr(3'd5, 8'h01);
    rd(3'd2); check("R6 enable readback", rdata, '1);

    // R1 / R10: global line 0 edge
    line[0] = 1; tick();
    rd(3'd0); check("R1 edge sets status bit0", rdata, 8'h01);
    check("R10 global bit0 irq", irq, 8'h01);
    // R8: held high, no overrun
    repeat (5) tick();
    rd(3'd1); check("R8 held line no error", rdata, '0);
    // R3: second edge
    line[0] = 0; tick(); line[0] = 1; tick();
    rd(3'd1); check("R3 second edge error", rdata, 8'h01);
    check("R4 err_irq with enable", {7'd0, err_irq}, 8'h01);
    wr(3'd1, 8'h01);
    rd(3'd1); check("R3 error cleared", rdata, '0);
    // R2: clear and new edge in same cycle
    line[0] = 0; tick();
    line[0] = 1; wr(3'd0, 8'h01);
    rd(3'd0); check("R2 edge wins over clear", rdata, 8'h01);
    line[0] = 0; wr(3'd0, 8'h01);
    wr(3'd1, 8'h01);
    rd(3'd0); check("R2 clear takes effect", rdata, '0);

    // R5: falling polarity on private line 5
    wr(3'd3, 8'h20); tick();
    rd(3'd0); check("R5 no phantom edge on arm", rdata, '0);
    line[5] = 1; tick();
    rd(3'd0); check("R5 rising ignored on falling line", rdata, '0);
    line[5] = 0; tick();
    rd(3'd0); check("R5 falling edge captured bit5", rdata, 8'h20);
    wr(3'd0, 8'h20);

    // R7: level mode on line 2
    wr(3'd4, 8'hFB);
    line[2] = 1; tick();
    rd(3'd0); check("R7 level follows line", rdata & 8'h04, 8'h04);
    wr(3'd0, 8'h04);
    rd(3'd0); check("R7 clear ignored in level", rdata & 8'h04, 8'h04);
    line[2] = 0; tick(); line[2] = 1; tick();
    rd(3'd1); check("R7 no error in level", rdata & 8'h04, 8'h00);
    line[2] = 0; tick();
    rd(3'd0); check("R7 level drops", rdata & 8'h04, 8'h00);

    // R4: error present, enable off
    line[1] = 1; tick(); line[1] = 0; tick(); line[1] = 1; tick();
    wr(3'd5, 8'h00);
    rd(3'd1); check("R4 error bit1 set", rdata & 8'h02, 8'h02);
    check("R4 err_irq masked", {7'd0, err_irq}, 8'h00);
    wr(3'd5, 8'h01);
    rd(3'd6); check("R10 unused address", rdata, '0);

    // random traffic, model compared each cycle
    for (int k = 0; k < 400; k++) begin
      line = N'($urandom);
      if (($urandom % 4) == 0) begin
        wr_en = 1; addr = 3'($urandom % 8); wdata = N'($urandom);
        if (addr == 3'd5) wdata[0] = ($urandom % 4) != 0;
      end else begin
        wr_en = 0; addr = 3'($urandom % 6);
      end
      tick();
    end
    wr_en = 0;
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule